// File: doc/BRIEF.md
# Dual-Width Register Access Port

A synchronous slave port that lets an external device on a local bus read and write a bank of 32-bit registers. The device presents a chip select, separate read and write strobes, a word address and four active-low byte enables. Each of these is sampled on the rising clock edge. A mode input chooses between a full 32-bit data path and a 16-bit data path. In 16-bit mode, each register is reached as two half-words. The most significant byte enable is reused as the half-word select. The port steers data and byte enables internally, so a 16-bit device needs no glue logic.

Write data is captured at the edge where the write is accepted. Read data leaves a register stage one cycle after the read is accepted. The pad-facing bus is split into an input, an output and two output enables, one per half-word. The chip-level pad ring builds the bidirectional bus from these signals. When an output enable is low, that half of the bus is left floating.

Top module: `dwr_port`

## Requirements
- R1: While rst_ni is low, every register is cleared to zero and both output enables are 0.
- R2: In 32-bit mode (mode16_i=0), a write is accepted when sel_ni=0 and wr_ni=0 at a rising edge. Each byte lane k (bits 8k+7:8k) of the addressed register takes dq_i at that edge only if be_ni[k]=0.
- R3: In 32-bit mode, a read accepted at a rising edge (sel_ni=0, rd_ni=0) drives the addressed register on dq_o[31:0] after that edge, with dq_oe_o=2'b11.
- R4: In 16-bit mode (mode16_i=1), be_ni[3] selects the half-word: 0 selects bits 15:0 and 1 selects bits 31:16. Write data comes from dq_i[15:0]. be_ni[0] gates the lower byte of the chosen half and be_ni[1] gates the upper byte. be_ni[2] and dq_i[31:16] are ignored, and the other half of the register is left unchanged.
- R5: In 16-bit mode, an accepted read places the half-word chosen by be_ni[3] on dq_o[15:0] after the edge, with dq_oe_o=2'b01, so bits 31:16 float.
- R6: With sel_ni=1, the read and write strobes have no effect: no register changes and no output enable rises.
- R7: In any cycle that does not follow an accepted read, dq_oe_o=2'b00.
- R8: In 16-bit mode, a lower half-word write followed by an upper half-word write to the same address builds the full 32-bit value, which a 32-bit read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode16_i | input | 1 | 1 selects 16-bit bus operation |
| sel_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| adr_i | input | 5 | Register word address |
| be_ni | input | 4 | Byte enables, active low; bit 3 selects the half-word in 16-bit mode |
| dq_i | input | 32 | Bus data from the pad |
| dq_o | output | 32 | Bus data to the pad |
| dq_oe_o | output | 2 | Output enable: bit 0 for bits 15:0, bit 1 for bits 31:16 |

## Verification
The bench builds the port with its default of 32 registers and a 32-bit word. This puts the top address, 31, within reach, together with every byte-lane combination of both half-words. The stimulus table mixes 32-bit and 16-bit accesses to the same registers. It covers partial byte-enable patterns, a half-word write that sets be_ni[2] and upper bus bits that must be ignored, and a word assembled from two half-word writes. Directed tests then cover deselected strobes, the idle bus, and clearing by reset after the registers hold data.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = DATA_W / BYTE_W;
  localparam int unsigned HBYTES = NBYTES / 2;
  localparam int unsigned HALF_W = DATA_W / 2;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dwr_wr_steer.sv
module dwr_wr_steer
  import dwr_pkg::*;
(
  input  logic              mode16_i,
  input  logic [NBYTES-1:0] be_ni,
  input  word_t             dq_i,
  output logic [NBYTES-1:0] lane_we_o,
  output word_t             wdata_o
);
  logic hi_sel;
  assign hi_sel = be_ni[NBYTES-1];

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    localparam int unsigned HB   = b % HBYTES;
    localparam bit          UPPR = (b >= HBYTES);
    // 16-bit mode: half-word lanes replicated onto both halves
    assign lane_we_o[b] = mode16_i ? ((hi_sel == UPPR) && !be_ni[HB]) : !be_ni[b];
    assign wdata_o[b*BYTE_W +: BYTE_W] =
      mode16_i ? dq_i[HB*BYTE_W +: BYTE_W] : dq_i[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/dwr_reg_bank.sv
module dwr_reg_bank
  import dwr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              adr_i,
  input  logic [NBYTES-1:0]              lane_we_i,
  input  word_t                          wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          regs_o[r][b*BYTE_W +: BYTE_W] <= '0;
        else if (we_i && lane_we_i[b] && (adr_i == ADDR_W'(r)))
          regs_o[r][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/dwr_rd_path.sv
module dwr_rd_path
  import dwr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            rd_i,
  input  logic                            mode16_i,
  input  logic                            hi_sel_i,
  input  logic [ADDR_W-1:0]               adr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output word_t                           dq_o,
  output logic [1:0]                      dq_oe_o
);
  word_t sel_word, next_dq;

  always_comb begin
    sel_word = regs_i[adr_i];
    if (mode16_i)
      next_dq = {{HALF_W{1'b0}}, hi_sel_i ? sel_word[DATA_W-1:HALF_W] : sel_word[HALF_W-1:0]};
    else
      next_dq = sel_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dq_oe_o <= 2'b00;
    end else if (rd_i) begin
      dq_o    <= next_dq;
      dq_oe_o <= mode16_i ? 2'b01 : 2'b11;
    end else begin
      dq_o    <= '0;
      dq_oe_o <= 2'b00;
    end
  end
endmodule

// File: rtl/dwr_port.sv
module dwr_port
  import dwr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode16_i,
  input  logic              sel_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [NBYTES-1:0] be_ni,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [1:0]        dq_oe_o
);
  logic                            wr_acc, rd_acc;
  logic [NBYTES-1:0]               lane_we;
  word_t                           wdata;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_w;

  assign wr_acc = !sel_ni && !wr_ni;
  assign rd_acc = !sel_ni && !rd_ni;

  dwr_wr_steer u_steer (
    .mode16_i (mode16_i),
    .be_ni    (be_ni),
    .dq_i     (dq_i),
    .lane_we_o(lane_we),
    .wdata_o  (wdata)
  );

  dwr_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_acc),
    .adr_i    (adr_i),
    .lane_we_i(lane_we),
    .wdata_i  (wdata),
    .regs_o   (regs_w)
  );

  dwr_rd_path #(.NUM_REGS(NUM_REGS)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_acc),
    .mode16_i(mode16_i),
    .hi_sel_i(be_ni[NBYTES-1]),
    .adr_i   (adr_i),
    .regs_i  (regs_w),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );
endmodule

// File: rtl/dwr_port_chk.sv
module dwr_port_chk
  import dwr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            mode16_i,
  input logic                            sel_ni,
  input logic                            wr_ni,
  input logic                            rd_ni,
  input logic [ADDR_W-1:0]               adr_i,
  input logic [NBYTES-1:0]               be_ni,
  input logic [1:0]                      dq_oe_o,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_w
);
  logic rd_ok, wr_ok;
  assign rd_ok = !sel_ni && !rd_ni;
  assign wr_ok = !sel_ni && !wr_ni;

  assert_full_read_oe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && !mode16_i |=> dq_oe_o == 2'b11);

  assert_half_read_oe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && mode16_i |=> dq_oe_o == 2'b01);

  assert_idle_float_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ok |=> dq_oe_o == 2'b00);

  assert_no_write_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok |=> $stable(regs_w));

  assert_upper_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok && mode16_i && !be_ni[NBYTES-1] |=>
      regs_w[$past(adr_i)][DATA_W-1:HALF_W] == $past(regs_w[adr_i][DATA_W-1:HALF_W]));

  assert_lower_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok && mode16_i && be_ni[NBYTES-1] |=>
      regs_w[$past(adr_i)][HALF_W-1:0] == $past(regs_w[adr_i][HALF_W-1:0]));

  assert_masked_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok && !mode16_i && (be_ni == '1) |=> $stable(regs_w));
endmodule

bind dwr_port dwr_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode16_i(mode16_i),
  .sel_ni  (sel_ni),
  .wr_ni   (wr_ni),
  .rd_ni   (rd_ni),
  .adr_i   (adr_i),
  .be_ni   (be_ni),
  .dq_oe_o (dq_oe_o),
  .regs_w  (regs_w)
);

// File: tb/sim_dwr_port.sv
module sim_dwr_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic        m16;
    logic        rd;
    logic [4:0]  adr;
    logic [3:0]  be_n;
    logic [31:0] data;  // write data or expected read value
  } vec_t;

  // R2/R3: 32-bit lanes; R4/R5: 16-bit halves (be_n[3] half select); R8: composed word
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 5'd3,  4'b0000, 32'h1122_3344},
    '{1'b0, 1'b1, 5'd3,  4'b0000, 32'h1122_3344},
    '{1'b0, 1'b0, 5'd3,  4'b1010, 32'hAABB_CCDD},
    '{1'b0, 1'b1, 5'd3,  4'b0000, 32'h11BB_33DD},
    '{1'b1, 1'b0, 5'd5,  4'b0100, 32'hFFFF_BEEF},
    '{1'b1, 1'b0, 5'd5,  4'b1000, 32'h1234_CAFE},
    '{1'b0, 1'b1, 5'd5,  4'b0000, 32'hCAFE_BEEF},
    '{1'b1, 1'b1, 5'd5,  4'b1000, 32'h0000_CAFE},
    '{1'b1, 1'b1, 5'd5,  4'b0000, 32'h0000_BEEF},
    '{1'b1, 1'b0, 5'd5,  4'b1110, 32'h0000_0055},
    '{1'b0, 1'b1, 5'd5,  4'b0000, 32'hCA55_BEEF},
    '{1'b1, 1'b0, 5'd31, 4'b0010, 32'h0000_0077},
    '{1'b0, 1'b1, 5'd31, 4'b0000, 32'h0000_0077}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode16 = 1'b0, sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [4:0]  adr = '0;
  logic [3:0]  be_n = '1;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic [1:0]  dq_oe;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwr_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode16_i(mode16), .sel_ni(sel_n),
    .wr_ni(wr_n), .rd_ni(rd_n), .adr_i(adr), .be_ni(be_n),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; be_n = '1; dq_in = '0;
  endtask

  // called at a negedge; returns at a negedge with the bus idle
  task automatic do_write(input logic m16, input logic [4:0] a, input logic [3:0] be,
                          input logic [31:0] d, input logic cs_n);
    mode16 = m16; sel_n = cs_n; wr_n = 1'b0; adr = a; be_n = be; dq_in = d;
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  task automatic do_read(input logic m16, input logic [4:0] a, input logic [3:0] be,
                         input logic cs_n, output logic [31:0] d, output logic [1:0] oe);
    mode16 = m16; sel_n = cs_n; rd_n = 1'b0; adr = a; be_n = be;
    @(negedge clk); d = dq_out; oe = dq_oe; idle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd_d;
    logic [1:0]  rd_oe;
    repeat (3) @(negedge clk);
    chk(dq_oe == 2'b00, "R1 oe in reset", {30'b0, dq_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_oe == 2'b00, "R7 idle bus", {30'b0, dq_oe}, 32'h0);
    do_read(1'b0, 5'd7, 4'b0000, 1'b0, rd_d, rd_oe);
    chk(rd_d == 32'h0, "R1 reg cleared", rd_d, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (!VEC[i].rd) begin
        do_write(VEC[i].m16, VEC[i].adr, VEC[i].be_n, VEC[i].data, 1'b0);
      end else begin
        do_read(VEC[i].m16, VEC[i].adr, VEC[i].be_n, 1'b0, rd_d, rd_oe);
        if (VEC[i].m16) begin
          chk(rd_d[15:0] == VEC[i].data[15:0], "R5 R4 R8 half read", {16'h0, rd_d[15:0]}, VEC[i].data);
          chk(rd_oe == 2'b01, "R5 half oe", {30'b0, rd_oe}, 32'h1);
        end else begin
          chk(rd_d == VEC[i].data, "R3 R2 R4 R8 word read", rd_d, VEC[i].data);
          chk(rd_oe == 2'b11, "R3 word oe", {30'b0, rd_oe}, 32'h3);
        end
      end
      chk(dq_oe == 2'b00, "R7 float after access", {30'b0, dq_oe}, 32'h0);
    end

    // R6: deselected write and read
    do_write(1'b0, 5'd3, 4'b0000, 32'hDEAD_0000, 1'b1);
    do_read(1'b0, 5'd3, 4'b0000, 1'b1, rd_d, rd_oe);
    chk(rd_oe == 2'b00, "R6 no drive when deselected", {30'b0, rd_oe}, 32'h0);
    do_read(1'b0, 5'd3, 4'b0000, 1'b0, rd_d, rd_oe);
    chk(rd_d == 32'h11BB_33DD, "R6 deselected write ignored", rd_d, 32'h11BB_33DD);

    // R2: all byte enables high writes nothing
    do_write(1'b0, 5'd31, 4'b1111, 32'hFFFF_FFFF, 1'b0);
    do_read(1'b0, 5'd31, 4'b0000, 1'b0, rd_d, rd_oe);
    chk(rd_d == 32'h0000_0077, "R2 masked write", rd_d, 32'h0000_0077);

    // R1: reset clears populated registers
    rst_n = 1'b0;
    @(negedge clk);
    chk(dq_oe == 2'b00, "R1 oe after reset", {30'b0, dq_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(1'b0, 5'd5, 4'b0000, 1'b0, rd_d, rd_oe);
    chk(rd_d == 32'h0, "R1 reg5 cleared", rd_d, 32'h0);
    do_read(1'b0, 5'd3, 4'b0000, 1'b0, rd_d, rd_oe);
    chk(rd_d == 32'h0, "R1 reg3 cleared", rd_d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule